// File: doc/BRIEF.md
# Multi-IO SPI Transaction Master

This block is a half-duplex SPI master that runs one complete transaction for each start request. A transaction has three phases: an 8-bit command byte, a 24-bit target address and then a number of data bytes. The caller presents the command, the address, the byte count and a clock divisor on plain input ports, then pulses `start`. Write bytes are taken one at a time from `wr_data`, and each byte that is taken is acknowledged. Read bytes come back as a stream of single-cycle `rd_valid` strobes.

The command byte always travels on one lane. It also sets the lane width of the address and data phases: one, two or four lanes. On a read command, the master drives the command and address, then releases every IO line so that the target can drive the data. SCK idles low and is sampled on its rising edge (mode 0). The SCK period is twice the programmed half-period count. The IO pins are modelled as separate output, output-enable and input vectors per lane.

Top module: `spim_master`

## Requirements
- R1: After reset, and whenever no transaction is running, `cs_n` is 1, `sck` is 0, `io_oe` is 0000 and `busy` is 0.
- R2: A transaction sends the command byte MSB first as 8 single-lane beats on IO0, then the 24-bit address MSB first, then the data bytes in order, MSB first. The number of SCK rising edges is 8 + 24/w + 8·N, divided by w for the address and data parts, where w is the lane width and N is the byte count.
- R3: Commands 0x02 and 0x0B use one lane. Commands 0xB2 and 0xBB use two lanes. Commands 0xE2 and 0xEB use four lanes. Only 0x0B, 0xBB and 0xEB are reads. Any other command value is a single-lane write.
- R4: During multi-lane beats, the highest-order bits of each beat go on the highest-numbered lane. `io_oe` is 0001 for one lane, 0011 for two lanes and 1111 for four lanes.
- R5: In single-lane mode, only IO0 is driven and read data is sampled from IO1.
- R6: On a read, `io_oe` is 0000 for the whole data phase. Input lanes are sampled on each SCK rising edge. Each assembled byte appears on `rd_data` with a one-cycle `rd_valid` strobe, in bus order.
- R7: On a write, `wr_ack` pulses once for each data byte, in the cycle in which that byte's first beat appears on the bus. `wr_data` must hold the byte that is to be sent next.
- R8: `cs_n` falls in the cycle after `start` is accepted, and the first SCK rising edge follows 2H cycles later. SCK then stays high for H cycles and low for H cycles. H is `div_half`, and a value of 0 acts as 1.
- R9: After the last high half, SCK stays low with `cs_n` low for H cycles. Then `cs_n` rises and `done` is high for exactly that one cycle.
- R10: A `start` that arrives while `busy` is 1 is ignored, and the running transaction continues unchanged.
- R11: While `cs_n` stays low, the driven IO values change only in cycles in which SCK has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| opcode | input | 8 | Command byte; selects direction and lane width |
| addr | input | 24 | Target address |
| nbytes | input | CNTW | Number of data bytes |
| div_half | input | DIVW | SCK half-period in system clocks (0 acts as 1) |
| wr_data | input | 8 | Next write byte |
| wr_ack | output | 1 | Pulse: `wr_data` has been taken |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Pulse: `rd_data` is valid |
| busy | output | 1 | A transaction is running |
| done | output | 1 | Pulse at the end of a transaction |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_oe | output | 4 | Per-lane output enable |
| io_o | output | 4 | Per-lane output value |
| io_i | input | 4 | Per-lane input value |

## Verification
The bench aims at the switch from the single-lane command to the wide address phase. There, a design that kept the wrong lane width would drive too many or too few address beats, and the whole remaining timeline would shift. Read transactions check that every output enable drops at the falling edge after the last address beat. A late release would fight the target, and a sample taken on the wrong edge would return bits shifted by one beat. Lane packing is checked in dual and quad modes: swapped lanes show up as bit-reversed nibbles. The bench also tests a divisor of zero, a zero-byte write, an unrecognised command and a start pulse in the middle of a transaction. A design that re-armed on that pulse would corrupt the rest of the cycle-by-cycle timeline.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // lane width as log2: value doubles as shift amount
  typedef enum logic [1:0] {LANE1 = 2'd0, LANE2 = 2'd1, LANE4 = 2'd2} lane_e;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_RUN, ST_TAIL} st_e;

  function automatic lane_e op_lanes(input logic [7:0] op);
    case (op)
      8'hBB, 8'hB2: return LANE2;
      8'hEB, 8'hE2: return LANE4;
      default:      return LANE1;
    endcase
  endfunction

  function automatic logic op_is_read(input logic [7:0] op);
    return (op == 8'h0B) || (op == 8'hBB) || (op == 8'hEB);
  endfunction

  function automatic int lane_w(input lane_e l);
    return 1 << int'(l);
  endfunction

  function automatic logic [3:0] lane_mask(input lane_e l);
    case (l)
      LANE1:   return 4'b0001;
      LANE2:   return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // top bits of a nibble onto lanes, highest bit on highest lane
  function automatic logic [3:0] pack_lanes(input logic [3:0] nib, input lane_e l);
    case (l)
      LANE1:   return {3'b000, nib[3]};
      LANE2:   return {2'b00, nib[3:2]};
      default: return nib;
    endcase
  endfunction

endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DIVW-1:0] half_m1,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = en && (cnt == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= half_m1));

endmodule

// File: rtl/spim_lanes.sv
module spim_lanes
  import spim_pkg::*;
(
  input  lane_e      mode,
  input  logic [3:0] drv_oe,
  input  logic [3:0] drv_val,
  input  logic [3:0] io_i,
  output logic [3:0] io_oe,
  output logic [3:0] io_o,
  output logic [3:0] rx_bits
);
  assign io_oe = drv_oe;
  assign io_o  = drv_val & drv_oe;

  always_comb begin
    case (mode)
      LANE1:   rx_bits = {3'b000, io_i[1]};
      LANE2:   rx_bits = {2'b00, io_i[1:0]};
      default: rx_bits = io_i;
    endcase
  end
endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int CNTW = 7,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      opcode,
  input  logic [23:0]     addr,
  input  logic [CNTW-1:0] nbytes,
  input  logic [DIVW-1:0] div_half,
  input  logic [7:0]      wr_data,
  output logic            wr_ack,
  output logic [7:0]      rd_data,
  output logic            rd_valid,
  output logic            busy,
  output logic            done,
  output logic            sck,
  output logic            cs_n,
  output logic [3:0]      io_oe,
  output logic [3:0]      io_o,
  input  logic [3:0]      io_i
);
  localparam int BEATW = $clog2(32 + 8 * (1 << CNTW)) + 1;

  st_e              st;
  lane_e            lane_q;
  logic             rd_q, lead_half, sck_r, cs_r;
  logic [31:0]      hsr, hsr_n;
  logic [7:0]       dsr, dsr_n, rsr, rsr_n, rdd_r, src;
  logic [2:0]       dpos, dpos_n, rpos, rpos_n;
  logic [BEATW-1:0] beat, nb, hdr_end, last_beat, s_hdr, s_dat;
  logic [DIVW-1:0]  half_m1;
  logic [3:0]       oe_r, o_r, l_oe, l_o, rx_bits;
  logic             done_r, rdv_r, wack_r, take;
  logic             tick;
  lane_e            s_lane;

  // named events for the checks below
  logic launch_ev, rise_ev, in_data, sample_ev;
  assign launch_ev = (st == ST_RUN) && tick && sck_r;
  assign rise_ev   = (st == ST_RUN) && tick && !sck_r;
  assign in_data   = (beat >= hdr_end);
  assign sample_ev = rise_ev && rd_q && in_data;

  spim_clkdiv #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .en(st != ST_IDLE), .half_m1(half_m1), .tick(tick)
  );

  spim_lanes u_lanes (
    .mode(lane_q), .drv_oe(oe_r), .drv_val(o_r), .io_i(io_i),
    .io_oe(io_oe), .io_o(io_o), .rx_bits(rx_bits)
  );

  // transaction geometry from the request
  assign s_lane = op_lanes(opcode);
  assign s_hdr  = BEATW'(8) + (BEATW'(24) >> int'(s_lane));
  assign s_dat  = (BEATW'(nbytes) << 3) >> int'(s_lane);

  // next beat to put on the bus
  always_comb begin
    nb     = beat + BEATW'(1);
    l_oe   = 4'b0000;
    l_o    = 4'b0000;
    hsr_n  = hsr;
    dsr_n  = dsr;
    dpos_n = dpos;
    take   = 1'b0;
    src    = (dpos == 3'd0) ? wr_data : dsr;
    if (nb < BEATW'(8)) begin
      l_oe  = 4'b0001;
      l_o   = {3'b000, hsr[31]};
      hsr_n = hsr << 1;
    end else if (nb < hdr_end) begin
      l_oe  = lane_mask(lane_q);
      l_o   = pack_lanes(hsr[31:28], lane_q);
      hsr_n = hsr << lane_w(lane_q);
    end else if (!rd_q) begin
      take   = (dpos == 3'd0);
      l_oe   = lane_mask(lane_q);
      l_o    = pack_lanes(src[7:4], lane_q);
      dsr_n  = src << lane_w(lane_q);
      dpos_n = dpos + 3'(lane_w(lane_q));
    end
  end

  // receive assembly
  assign rsr_n  = (rsr << lane_w(lane_q)) | {4'b0000, rx_bits};
  assign rpos_n = rpos + 3'(lane_w(lane_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; lane_q <= LANE1; rd_q <= 1'b0; lead_half <= 1'b0;
      sck_r <= 1'b0; cs_r <= 1'b1; hsr <= '0; dsr <= '0; rsr <= '0;
      rdd_r <= '0; dpos <= '0; rpos <= '0; beat <= '0; hdr_end <= '0;
      last_beat <= '0; half_m1 <= '0; oe_r <= '0; o_r <= '0;
      done_r <= 1'b0; rdv_r <= 1'b0; wack_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      rdv_r  <= 1'b0;
      wack_r <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st        <= ST_LEAD;
          cs_r      <= 1'b0;
          lane_q    <= s_lane;
          rd_q      <= op_is_read(opcode);
          hdr_end   <= s_hdr;
          last_beat <= s_hdr + s_dat - BEATW'(1);
          half_m1   <= (div_half == '0) ? '0 : div_half - 1'b1;
          lead_half <= 1'b0;
          beat      <= '0;
          hsr       <= {opcode[6:0], addr, 1'b0};
          oe_r      <= 4'b0001;
          o_r       <= {3'b000, opcode[7]};
          dpos      <= '0;
          rpos      <= '0;
        end
        ST_LEAD: if (tick) begin
          if (lead_half) begin
            sck_r <= 1'b1;
            st    <= ST_RUN;
          end
          lead_half <= 1'b1;
        end
        ST_RUN: if (tick) begin
          if (sck_r) begin
            sck_r <= 1'b0;
            if (beat == last_beat) begin
              st   <= ST_TAIL;
              oe_r <= 4'b0000;
              o_r  <= 4'b0000;
            end else begin
              beat   <= nb;
              oe_r   <= l_oe;
              o_r    <= l_o;
              hsr    <= hsr_n;
              dsr    <= dsr_n;
              dpos   <= dpos_n;
              wack_r <= take;
            end
          end else begin
            sck_r <= 1'b1;
            if (sample_ev) begin
              rsr  <= rsr_n;
              rpos <= rpos_n;
              if (rpos_n == 3'd0) begin
                rdv_r <= 1'b1;
                rdd_r <= rsr_n;
              end
            end
          end
        end
        ST_TAIL: if (tick) begin
          cs_r   <= 1'b1;
          st     <= ST_IDLE;
          done_r <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sck      = sck_r;
  assign cs_n     = cs_r;
  assign busy     = (st != ST_IDLE);
  assign done     = done_r;
  assign rd_valid = rdv_r;
  assign rd_data  = rdd_r;
  assign wr_ack   = wack_r;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sck && io_oe == 4'b0000));
  // R4
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe inside {4'b0000, 4'b0001, 4'b0011, 4'b1111});
  // R5
  single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_q == LANE1 && !cs_n) |-> (io_oe[3:1] == 3'b000));
  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && rd_q && in_data) |-> (io_oe == 4'b0000));
  // R8
  sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sck));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);
  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(last_beat) && $stable(hdr_end)));
  // R11
  mode0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(io_o) && !cs_n && !$fell(cs_n)) |-> $fell(sck));

endmodule

// File: tb/tb_spim_master.sv
`timescale 1ns/1ps
module tb_spim_master;
  localparam int CNTW = 7;
  localparam int DIVW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [7:0]      opcode = '0;
  logic [23:0]     addr = '0;
  logic [CNTW-1:0] nbytes = '0;
  logic [DIVW-1:0] div_half = '0;
  logic [7:0]      wr_data = '0;
  logic            wr_ack, rd_valid, busy, done, sck, cs_n;
  logic [7:0]      rd_data;
  logic [3:0]      io_oe, io_o;
  logic [3:0]      io_i = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spim_master #(.CNTW(CNTW), .DIVW(DIVW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr),
    .nbytes(nbytes), .div_half(div_half), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .sck(sck), .cs_n(cs_n), .io_oe(io_oe), .io_o(io_o), .io_i(io_i)
  );

  typedef struct packed {
    logic       done;
    logic       cs_n;
    logic       sck;
    logic [3:0] oe;
    logic [3:0] o;
    logic [3:0] iin;
  } step_t;

  step_t      tl[$];
  logic [7:0] wb[$];
  logic [7:0] rb[$];

  function automatic int lanes_of(logic [7:0] op);
    if (op == 8'hBB || op == 8'hB2) return 2;
    if (op == 8'hEB || op == 8'hE2) return 4;
    return 1;
  endfunction

  function automatic bit is_rd(logic [7:0] op);
    return op == 8'h0B || op == 8'hBB || op == 8'hEB;
  endfunction

  // bus contents expected during beat k
  function automatic step_t beat_step(int k, logic [7:0] op, logic [23:0] ad, int w, bit rd);
    step_t s;
    int msk;
    msk = (1 << w) - 1;
    s = '0;
    s.iin = 4'h5;
    if (k < 8) begin
      s.oe = 4'b0001;
      s.o  = {3'b000, op[7-k]};
    end else if (k < 8 + 24 / w) begin
      int a;
      a = k - 8;
      s.oe = 4'(msk);
      s.o  = 4'((int'(ad) >> (24 - (a + 1) * w)) & msk);
    end else begin
      int j, bi, sh, bits;
      j  = k - 8 - 24 / w;
      bi = (j * w) / 8;
      sh = 8 - ((j * w) % 8) - w;
      if (rd) begin
        bits  = (int'(rb[bi]) >> sh) & msk;
        s.oe  = 4'b0000;
        s.o   = 4'b0000;
        s.iin = (w == 1) ? 4'(bits << 1) : 4'(bits);
      end else begin
        bits = (int'(wb[bi]) >> sh) & msk;
        s.oe = 4'(msk);
        s.o  = 4'(bits);
      end
    end
    return s;
  endfunction

  task automatic run_txn(string tag, logic [7:0] op, logic [23:0] ad, int n, int dh);
    int w, hh, nbeats, widx, acks;
    bit rd;
    step_t s;
    logic [7:0] got[$];
    w = lanes_of(op);
    rd = is_rd(op);
    hh = (dh == 0) ? 1 : dh;
    nbeats = 8 + 24 / w + (n * 8) / w;
    widx = 0;
    acks = 0;
    tl.delete();
    s = beat_step(0, op, ad, w, rd);
    repeat (2 * hh) tl.push_back(s);
    for (int k = 0; k < nbeats; k++) begin
      s = beat_step(k, op, ad, w, rd);
      s.sck = 1'b1;
      repeat (hh) tl.push_back(s);
      if (k < nbeats - 1) s = beat_step(k + 1, op, ad, w, rd);
      else begin s = '0; s.iin = 4'h5; end
      s.sck = 1'b0;
      repeat (hh) tl.push_back(s);
    end
    s = '0; s.cs_n = 1'b1; s.done = 1'b1; s.iin = 4'h5;
    tl.push_back(s);

    @(negedge clk);
    opcode = op; addr = ad; nbytes = CNTW'(n); div_half = DIVW'(dh);
    wr_data = (n > 0 && !rd) ? wb[0] : 8'h00;
    start = 1'b1;
    for (int i = 0; i < tl.size(); i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      // R10: stray request mid-transaction, with different fields
      if (i == 3) begin start = 1'b1; opcode = 8'hE2; nbytes = CNTW'(1); end
      if (i == 4) start = 1'b0;
      checks++;
      // R2 R3 R4 R5 R8 R9 R11: full per-cycle bus timeline
      if ({done, cs_n, sck, io_oe, io_o} !== {tl[i].done, tl[i].cs_n, tl[i].sck, tl[i].oe, tl[i].o}
          || busy !== !tl[i].cs_n) begin
        fails++;
        $display("FAIL R2 %s cycle %0d: got done=%b cs_n=%b sck=%b oe=%b o=%b busy=%b exp done=%b cs_n=%b sck=%b oe=%b o=%b busy=%b",
                 tag, i, done, cs_n, sck, io_oe, io_o, busy,
                 tl[i].done, tl[i].cs_n, tl[i].sck, tl[i].oe, tl[i].o, !tl[i].cs_n);
      end
      if (wr_ack) begin
        acks++;
        widx++;
        if (widx < wb.size()) wr_data = wb[widx];
      end
      if (rd_valid) got.push_back(rd_data);
      io_i = tl[i].iin;
    end

    // R7: one acknowledge per written byte, none on reads
    checks++;
    if (acks != (rd ? 0 : n)) begin
      fails++;
      $display("FAIL R7 %s: got acks=%0d exp %0d", tag, acks, rd ? 0 : n);
    end
    // R6: read bytes in bus order
    if (rd) begin
      checks++;
      if (got.size() != n) begin
        fails++;
        $display("FAIL R6 %s: got %0d bytes exp %0d", tag, got.size(), n);
      end else begin
        for (int b = 0; b < n; b++) begin
          checks++;
          if (got[b] !== rb[b]) begin
            fails++;
            $display("FAIL R6 %s byte %0d: got %h exp %h", tag, b, got[b], rb[b]);
          end
        end
      end
    end
    // R9: done lasts one cycle, block idle afterwards
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || cs_n !== 1'b1 || busy !== 1'b0 || sck !== 1'b0) begin
      fails++;
      $display("FAIL R9 %s after end: got done=%b cs_n=%b busy=%b sck=%b exp 0 1 0 0",
               tag, done, cs_n, busy, sck);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (cs_n !== 1'b1 || sck !== 1'b0 || io_oe !== 4'b0000 || busy !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got cs_n=%b sck=%b oe=%b busy=%b exp 1 0 0000 0", cs_n, sck, io_oe, busy);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (cs_n !== 1'b1 || sck !== 1'b0 || io_oe !== 4'b0000 || busy !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle: got cs_n=%b sck=%b oe=%b busy=%b exp 1 0 0000 0", cs_n, sck, io_oe, busy);
    end

    // R4: quad write, lane packing
    wb = '{8'hA5, 8'h3C}; rb = '{};
    run_txn("quad_wr", 8'hE2, 24'h123456, 2, 1);
    // R5 R6: single-lane read, data on IO1
    wb = '{}; rb = '{8'h96, 8'h01, 8'hFF};
    run_txn("single_rd", 8'h0B, 24'hABCDEF, 3, 2);
    // R8: divisor 0 behaves as 1, dual read
    rb = '{8'hC3, 8'h5A};
    run_txn("dual_rd_div0", 8'hBB, 24'h00F0F0, 2, 0);
    // R4: dual write, slow clock
    wb = '{8'h81}; rb = '{};
    run_txn("dual_wr", 8'hB2, 24'h800001, 1, 3);
    // R6: quad read
    wb = '{}; rb = '{8'h12, 8'h34, 8'hEF, 8'h70};
    run_txn("quad_rd", 8'hEB, 24'h0A0B0C, 4, 1);
    // R3: unrecognised command -> single-lane write
    wb = '{8'hC6}; rb = '{};
    run_txn("unknown_op", 8'h5A, 24'h7FFFFF, 1, 1);
    // R2: zero data bytes, header only
    wb = '{}; rb = '{};
    run_txn("hdr_only", 8'h02, 24'h000000, 0, 2);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule